// File: doc/BRIEF.md
# Fuse array read sequencer

This block reads a window of bytes out of a one-time-programmable fuse array that holds 32 words of 32 bits, 128 bytes in all. A requester gives a byte offset and a byte count with a single-cycle valid pulse while the block is not busy. The block turns the byte window into a loop over word addresses and drives the array's control word through a fixed sequence. First it enters read mode and waits one settle interval. For each word it raises the strobe with the word address, waits, samples the data, lowers the strobe and waits again. After the last word it puts the array into standby.

From every sampled word the block forwards only the bytes that lie inside the window, one byte per cycle on a byte stream, lowest address first. The first byte comes from the in-word position of the offset. Reads that would run past the end of the array stop at the last word. Requests that are malformed finish at once with an error flag and never touch the array. The settle interval is a cycle count set by a parameter.

Top module: `fuse_read_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `fuse_ctrl` equals the standby word 0x0000_0021 (bit 0 chip-deselect and bit 5 power-down high, all else low), and `byte_valid`, `done` and `err` are low.
- R2: The cycle after a valid request is accepted, `fuse_ctrl` becomes the read-mode word 0x0000_028C (bits 2, 3, 7 and 9 high, bits 0 and 5 low). It stays there for exactly SETTLE_CYC cycles before the first strobe.
- R3: Each word access drives bit 1 (strobe) high together with the read-mode bits and the word address in bits 25:16, for exactly SETTLE_CYC cycles. The strobe then stays low for at least SETTLE_CYC cycles before the next strobe or standby.
- R4: The strobed word addresses start at offset/4 and rise by one per access. The last one is ceil((offset+n)/4)-1, where n is the delivered byte count, so no address exceeds 31.
- R5: Bytes are delivered in ascending array order. Byte k of a word is taken from its bits 8k+7:8k (little-endian), and the first byte delivered is array byte `offset`.
- R6: The number of bytes delivered equals min(count, 128-offset).
- R7: After the last word the control word returns to standby. `done` pulses high for one cycle with `err` low in the first standby cycle.
- R8: A request with offset of 128 or more, or a count of zero, yields `done` and `err` high in the next cycle, with no strobe, no byte and no change of `fuse_ctrl`.
- R9: A request presented while `busy` is high is ignored: the read in progress delivers the same bytes and addresses, and only one `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_offset | input | 8 | Starting byte offset |
| req_count | input | 8 | Number of bytes wanted |
| busy | output | 1 | A read is in progress |
| fuse_ctrl | output | 32 | Control word to the fuse array |
| fuse_dout | input | 32 | Data word from the fuse array |
| byte_valid | output | 1 | byte_data carries a window byte |
| byte_data | output | 8 | Delivered byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a rejected request |

## Verification
The hardest case to reach is the tail of the array, where an unaligned window is both cut short at byte 127 and starts mid-word. The bench sweeps every offset from 0 to 127 against counts that end inside the first word, exactly fill it, cross one boundary and overrun the array, and so reaches every in-word start position combined with truncation. A second request raised during a long read checks that the busy interlock leaves the stream untouched. Offsets at and beyond 128 and zero counts check the rejection path.

// File: rtl/fuse_read_seq.sv
module fuse_read_seq #(
  parameter int SETTLE_CYC = 100,
  parameter int WORDS = 32,
  localparam int OW = $clog2(WORDS * 4) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [OW-1:0] req_offset,
  input  logic [OW-1:0] req_count,
  output logic          busy,
  output logic [31:0]   fuse_ctrl,
  input  logic [31:0]   fuse_dout,
  output logic          byte_valid,
  output logic [7:0]    byte_data,
  output logic          done,
  output logic          err
);

  localparam int BYTES = WORDS * 4;
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [31:0] STBY = 32'h0000_0021;
  localparam logic [31:0] RDMODE = 32'h0000_028C;
  localparam logic [31:0] STRB_BIT = 32'h0000_0002;
  localparam logic [CW-1:0] TLOAD = CW'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_STRB, S_EMIT, S_LOW} st_t;

  st_t st, st_n;
  logic [AW-1:0] addr, addr_n;
  logic [1:0] pos, pos_n;
  logic [OW-1:0] rem, rem_n;
  logic [CW-1:0] tmr, tmr_n;
  logic [31:0] word, word_n;
  logic [31:0] ctrl_q, ctrl_n;
  logic done_n, err_n;

  logic bad;
  logic [OW-1:0] avail, take;
  assign bad = (req_offset >= OW'(BYTES)) || (req_count == '0);
  assign avail = OW'(BYTES) - req_offset;
  assign take = (req_count < avail) ? req_count : avail;

  always_comb begin
    st_n = st;
    addr_n = addr;
    pos_n = pos;
    rem_n = rem;
    tmr_n = tmr;
    word_n = word;
    done_n = 1'b0;
    err_n = 1'b0;
    case (st)
      S_IDLE: if (req_valid) begin
        if (bad) begin
          done_n = 1'b1;
          err_n = 1'b1;
        end else begin
          st_n = S_OPEN;
          addr_n = req_offset[OW-2:2];
          pos_n = req_offset[1:0];
          rem_n = take;
          tmr_n = TLOAD;
        end
      end
      S_OPEN: begin
        if (tmr == '0) begin
          st_n = S_STRB;
          tmr_n = TLOAD;
        end else tmr_n = tmr - 1'b1;
      end
      S_STRB: begin
        if (tmr == '0) begin
          word_n = fuse_dout;
          st_n = S_EMIT;
        end else tmr_n = tmr - 1'b1;
      end
      S_EMIT: begin
        pos_n = pos + 1'b1;
        rem_n = rem - 1'b1;
        if (rem == OW'(1) || pos == 2'd3) begin
          st_n = S_LOW;
          tmr_n = TLOAD;
        end
      end
      S_LOW: begin
        if (tmr == '0) begin
          if (rem == '0) begin
            st_n = S_IDLE;
            done_n = 1'b1;
          end else begin
            st_n = S_STRB;
            addr_n = addr + 1'b1;
            pos_n = 2'd0;
            tmr_n = TLOAD;
          end
        end else tmr_n = tmr - 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_n)
      S_IDLE:  ctrl_n = STBY;
      S_STRB:  ctrl_n = RDMODE | STRB_BIT | (32'(addr_n) << 16);
      default: ctrl_n = RDMODE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr <= '0;
      pos <= '0;
      rem <= '0;
      tmr <= '0;
      word <= '0;
      ctrl_q <= STBY;
      done <= 1'b0;
      err <= 1'b0;
    end else begin
      st <= st_n;
      addr <= addr_n;
      pos <= pos_n;
      rem <= rem_n;
      tmr <= tmr_n;
      word <= word_n;
      ctrl_q <= ctrl_n;
      done <= done_n;
      err <= err_n;
    end
  end

  assign fuse_ctrl = ctrl_q;
  assign busy = (st != S_IDLE);
  assign byte_valid = (st == S_EMIT);
  assign byte_data = word[{pos, 3'b000} +: 8];

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> fuse_ctrl == STBY);
  p_strobe_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_ctrl[1]) |-> $past(fuse_ctrl) == RDMODE);
  p_strobe_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctrl[1] |-> (fuse_ctrl & ~32'h03FF_0000) == (RDMODE | STRB_BIT));
  p_strobe_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctrl[1] |-> fuse_ctrl[25:16] < 10'(WORDS));
  p_byte_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> busy && !fuse_ctrl[1]);
  p_done_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> fuse_ctrl == STBY && $past(busy));
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !busy);
  p_err_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(busy));

endmodule

// File: tb/fuse_read_seq_tb.sv
module fuse_read_seq_tb_top;
  localparam int S = 3;
  localparam logic [31:0] STBY = 32'h21;
  localparam logic [31:0] RDM = 32'h28C;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [7:0] req_offset = 0, req_count = 0;
  logic busy, byte_valid, done, err;
  logic [31:0] fuse_ctrl, fuse_dout;
  logic [7:0] byte_data;

  int compared = 0, mismatched = 0;
  int nb, na, ndone, nerr;
  logic [7:0] got [0:255];
  int addrs [0:63];
  logic [31:0] prev_ctrl = 32'h21;
  int run = 0;
  bit open_flag = 0;

  always #2 clk = ~clk;

  fuse_read_seq #(.SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .busy(busy), .fuse_ctrl(fuse_ctrl), .fuse_dout(fuse_dout),
    .byte_valid(byte_valid), .byte_data(byte_data), .done(done), .err(err));

  function automatic logic [7:0] fb(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] fword(input int a);
    return {fb(4*a+3), fb(4*a+2), fb(4*a+1), fb(4*a)};
  endfunction

  assign fuse_dout = (fuse_ctrl[1] && fuse_ctrl[2]) ? fword(int'(fuse_ctrl[20:16])) : 32'hFFFF_FFFF;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (byte_valid && nb < 256) begin got[nb] = byte_data; nb++; end
    if (fuse_ctrl[1] && !prev_ctrl[1] && na < 64) begin addrs[na] = int'(fuse_ctrl[25:16]); na++; end
    if (done) ndone++;
    if (err) nerr++;
    if (fuse_ctrl == prev_ctrl) run++;
    else begin
      if (prev_ctrl[1]) chk(run == S, "R3 strobe width", run, S);
      else if (prev_ctrl == RDM) begin
        if (open_flag) begin chk(run == S, "R2 open wait", run, S); open_flag = 0; end
        else chk(run >= S + 1, "R3 low wait", run, S + 1);
      end
      if (prev_ctrl == STBY) begin
        chk(fuse_ctrl == RDM, "R2 read mode word", int'(fuse_ctrl), int'(RDM));
        open_flag = 1;
      end
      prev_ctrl = fuse_ctrl;
      run = 1;
    end
  end

  task automatic do_req(input int off, input int cnt, input bit inject);
    int exp_n, first, nw, t;
    bit bad;
    nb = 0; na = 0; ndone = 0; nerr = 0;
    req_offset = 8'(off); req_count = 8'(cnt); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (inject) begin
      repeat (5) @(negedge clk);
      req_offset = 8'd5; req_count = 8'd2; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    t = 0;
    while (ndone == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    bad = (off >= 128) || (cnt == 0);
    exp_n = bad ? 0 : ((cnt < 128 - off) ? cnt : 128 - off);
    chk(nb == exp_n, "R6 byte count", nb, exp_n);
    for (int i = 0; i < exp_n && i < nb; i++)
      chk(got[i] == fb(off + i), "R5 byte value", int'(got[i]), int'(fb(off + i)));
    if (!bad) begin
      first = off / 4;
      nw = (off % 4 + exp_n + 3) / 4;
      chk(na == nw, "R4 word count", na, nw);
      for (int j = 0; j < nw && j < na; j++)
        chk(addrs[j] == first + j, "R4 word address", addrs[j], first + j);
      chk(nerr == 0, "R7 no error", nerr, 0);
    end else begin
      chk(na == 0 && nb == 0, "R8 no access", na + nb, 0);
      chk(nerr == 1, "R8 error flag", nerr, 1);
    end
    chk(ndone == 1, inject ? "R9 single done" : "R7 done pulse", ndone, 1);
    chk(fuse_ctrl == STBY && !busy, "R7 standby", int'(fuse_ctrl), int'(STBY));
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int counts [7] = '{1, 2, 3, 4, 5, 8, 130};
    repeat (3) @(negedge clk);
    chk(fuse_ctrl == STBY, "R1 reset ctrl", int'(fuse_ctrl), int'(STBY));
    chk(!busy && !byte_valid && !done && !err, "R1 reset flags",
        int'({busy, byte_valid, done, err}), 0);
    rst_n = 1;
    @(negedge clk);
    for (int off = 0; off < 128; off++)
      foreach (counts[k]) do_req(off, counts[k], 0);
    do_req(0, 255, 0);
    do_req(124, 9, 0);
    do_req(127, 1, 0);
    do_req(128, 4, 0);
    do_req(200, 1, 0);
    do_req(255, 255, 0);
    do_req(10, 0, 0);
    do_req(0, 128, 1);
    do_req(33, 50, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule